// File: doc/BRIEF.md
# Single-Wire Bus Device-Side Slot Responder

This block sits on the device end of a single-wire open-drain bus. The bus idles high through a pull-up, and the block reads it through a line input that is already synchronized to the clock. It pulls the bus low through one open-drain control output. The master starts every transaction with a falling edge. The block times everything from that edge with a single cycle counter. A write slot becomes one received bit by sampling the line at a fixed point. A read slot is answered either by leaving the line alone or by stretching the master's low pulse.

A low lasting longer than the reset threshold is taken as a bus reset. When the master lets go of the line, the block waits a short gap and then drives a presence pulse. A mode input chooses how the next slot is handled. When it is low, the slot is a write slot and produces a one-cycle received-bit strobe. When it is high, the slot is a read response that carries the transmit-bit input. Byte assembly and command handling belong to the logic around this block.

Top module: `owr_responder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pull_low_o`, `rx_valid_o` and `reset_seen_o` are all 0.
- R2: In a write slot (`tx_mode_i`=0 at the falling edge), `rx_valid_o` pulses for exactly one cycle SAMPLE_US after the falling edge. `rx_bit_o` then holds the line level at that instant: high gives 1 and low gives 0.
- R3: A slot started while `tx_mode_i`=1 (read response) never produces an `rx_valid_o` pulse.
- R4: In a read slot with `tx_bit_i`=0, the line is held low from the falling edge until TX0_US later. With `tx_bit_i`=1, `pull_low_o` stays 0, so the line reads high 12 µs into the slot.
- R5: A transmitted 0 is released before the 60 µs slot ends. `pull_low_o` is 0 whenever no slot or presence pulse is in progress.
- R6: A continuous low of RESET_US gives exactly one `reset_seen_o` pulse. `pull_low_o` stays 0 for the rest of that low.
- R7: After the reset low is released, the block waits PRES_WAIT_US and then holds `pull_low_o` high for PRES_LEN_US.
- R8: Falling edges that arrive between reset release and the end of the presence pulse do not start slots. They produce no strobe and leave the presence timing unchanged.
- R9: A new reset low during the presence sequence restarts it. A second `reset_seen_o` pulse is given, and the presence pulse is timed from the new release.
- R10: In write slots the block never pulls the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronized bus level (1 = released/high) |
| tx_mode_i | input | 1 | 1 = next slot is a read response, 0 = write slot |
| tx_bit_i | input | 1 | Bit sent in the next read response slot |
| pull_low_o | output | 1 | 1 = drive the open-drain bus low |
| rx_valid_o | output | 1 | One-cycle strobe for a received write bit |
| rx_bit_o | output | 1 | Received write bit, valid with the strobe |
| reset_seen_o | output | 1 | One-cycle strobe when a reset low is detected |

## Verification
The assertions take a few things for granted about the inputs. `line_i` is the wired-AND of the master and this block, already synchronized. The master holds every slot for at least 60 µs. `tx_mode_i` and `tx_bit_i` are settled before the falling edge that starts a slot. The bench models the bus as the AND of its own master drive and `pull_low_o`. It changes the master drive and the mode inputs only on falling clock edges and always ends a slot with recovery time at the high level. The reset stimulus uses lows well above the threshold, and the glitch stimulus uses short lows well below it, so no input sits exactly on a timing boundary.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RST_HOLD,
        ST_PRES_WAIT,
        ST_PRES
    } owr_state_e;

    typedef struct packed {
        logic rd_mode;
        logic tx_bit;
    } owr_slot_t;

    typedef struct packed {
        logic valid;
        logic data;
    } owr_rx_t;

    function automatic int unsigned owr_cycles(input int unsigned usec,
                                               input int unsigned per_us);
        return usec * per_us;
    endfunction

    function automatic int unsigned owr_max(input int unsigned a,
                                            input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned owr_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/owr_line_mon.sv
module owr_line_mon
    import owr_pkg::*;
#(
    parameter int unsigned RESET_CYC = 24000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o,
    output logic rst_hit_o
);
    localparam int unsigned LW = owr_width(RESET_CYC);
    localparam logic [LW-1:0] HIT_AT = LW'(RESET_CYC - 1);
    localparam logic [LW-1:0] SAT_AT = LW'(RESET_CYC);

    logic          line_q;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            line_q <= line_i;
            if (line_i) begin
                low_cnt <= '0;
            end else if (low_cnt != SAT_AT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign fall_o    = line_q & ~line_i;
    assign rst_hit_o = ~line_i & (low_cnt == HIT_AT);

    // R6: one detection per continuous low
    assert_hit_single_R6: assert property (@(posedge clk) disable iff (rst)
        rst_hit_o |=> !rst_hit_o);

    // R6: detection only while line low
    assert_hit_on_low_R6: assert property (@(posedge clk) disable iff (rst)
        rst_hit_o |-> $past(line_i) == 1'b0 || !line_q);

endmodule

// File: rtl/owr_slot_ctrl.sv
module owr_slot_ctrl
    import owr_pkg::*;
#(
    parameter int unsigned SAMPLE_CYC = 1500,
    parameter int unsigned TX0_CYC    = 1500,
    parameter int unsigned PW_CYC     = 1500,
    parameter int unsigned PL_CYC     = 6000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    line_i,
    input  logic    fall_i,
    input  logic    rst_hit_i,
    input  logic    rd_mode_i,
    input  logic    tx_bit_i,
    output logic    pull_o,
    output owr_rx_t rx_o,
    output logic    reset_seen_o
);
    localparam int unsigned END_CYC = owr_max(SAMPLE_CYC, TX0_CYC);
    localparam int unsigned TOP_CYC = owr_max(END_CYC, owr_max(PW_CYC, PL_CYC));
    localparam int unsigned CW      = owr_width(TOP_CYC);
    localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0] TX0_LAST    = CW'(TX0_CYC - 1);
    localparam logic [CW-1:0] END_LAST    = CW'(END_CYC - 1);
    localparam logic [CW-1:0] PW_LAST     = CW'(PW_CYC - 1);
    localparam logic [CW-1:0] PL_LAST     = CW'(PL_CYC - 1);

    owr_state_e    state;
    owr_slot_t     slot;
    logic [CW-1:0] cnt;
    logic          pull_q;
    owr_rx_t       rx_q;
    logic          rs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            slot   <= '0;
            cnt    <= '0;
            pull_q <= 1'b0;
            rx_q   <= '0;
            rs_q   <= 1'b0;
        end else begin
            rx_q.valid <= 1'b0;
            rs_q       <= 1'b0;
            if (rst_hit_i) begin
                state  <= ST_RST_HOLD;
                pull_q <= 1'b0;
                rs_q   <= 1'b1;
                cnt    <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (fall_i) begin
                            state        <= ST_SLOT;
                            slot.rd_mode <= rd_mode_i;
                            slot.tx_bit  <= tx_bit_i;
                            pull_q       <= rd_mode_i & ~tx_bit_i;
                        end
                    end
                    ST_SLOT: begin
                        cnt <= cnt + 1'b1;
                        if (!slot.rd_mode && cnt == SAMPLE_LAST) begin
                            rx_q.valid <= 1'b1;
                            rx_q.data  <= line_i;
                        end
                        if (cnt == TX0_LAST) begin
                            pull_q <= 1'b0;
                        end
                        if (cnt == END_LAST) begin
                            state  <= ST_IDLE;
                            pull_q <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    ST_RST_HOLD: begin
                        cnt <= '0;
                        if (line_i) begin
                            state <= ST_PRES_WAIT;
                        end
                    end
                    ST_PRES_WAIT: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == PW_LAST) begin
                            state  <= ST_PRES;
                            pull_q <= 1'b1;
                            cnt    <= '0;
                        end
                    end
                    ST_PRES: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == PL_LAST) begin
                            state  <= ST_IDLE;
                            pull_q <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    default: begin
                        state  <= ST_IDLE;
                        pull_q <= 1'b0;
                        cnt    <= '0;
                    end
                endcase
            end
        end
    end

    assign pull_o       = pull_q;
    assign rx_o         = rx_q;
    assign reset_seen_o = rs_q;

    // R2: strobe lasts one cycle
    assert_rx_single_R2: assert property (@(posedge clk) disable iff (rst)
        rx_q.valid |=> !rx_q.valid);

    // R3: strobe only for write slots
    assert_rx_write_only_R3: assert property (@(posedge clk) disable iff (rst)
        rx_q.valid |-> !slot.rd_mode);

    // R5: released whenever no slot or presence is active
    assert_idle_released_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_RST_HOLD || state == ST_PRES_WAIT) |-> !pull_q);

    // R5: once released inside a slot, not re-asserted
    assert_no_repull_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && $past(state) == ST_SLOT && !$past(pull_q)) |-> !pull_q);

    // R7: presence is entered only from the wait gap
    assert_presence_order_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRES && $past(state) != ST_PRES) |-> $past(state) == ST_PRES_WAIT);

    // R6: reset strobe is a single cycle
    assert_reset_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        rs_q |=> !rs_q);

    // R10: write slots never drive the line
    assert_write_no_pull_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && !slot.rd_mode) |-> !pull_q);

endmodule

// File: rtl/owr_responder.sv
module owr_responder
    import owr_pkg::*;
#(
    parameter int unsigned CLK_PER_US   = 50,
    parameter int unsigned SAMPLE_US    = 30,
    parameter int unsigned RESET_US     = 480,
    parameter int unsigned PRES_WAIT_US = 30,
    parameter int unsigned PRES_LEN_US  = 120,
    parameter int unsigned TX0_US       = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic tx_mode_i,
    input  logic tx_bit_i,
    output logic pull_low_o,
    output logic rx_valid_o,
    output logic rx_bit_o,
    output logic reset_seen_o
);
    localparam int unsigned SAMPLE_CYC = owr_cycles(SAMPLE_US, CLK_PER_US);
    localparam int unsigned RESET_CYC  = owr_cycles(RESET_US, CLK_PER_US);
    localparam int unsigned PW_CYC     = owr_cycles(PRES_WAIT_US, CLK_PER_US);
    localparam int unsigned PL_CYC     = owr_cycles(PRES_LEN_US, CLK_PER_US);
    localparam int unsigned TX0_CYC    = owr_cycles(TX0_US, CLK_PER_US);

    logic    fall;
    logic    rst_hit;
    owr_rx_t rx;

    owr_line_mon #(
        .RESET_CYC(RESET_CYC)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .line_i   (line_i),
        .fall_o   (fall),
        .rst_hit_o(rst_hit)
    );

    owr_slot_ctrl #(
        .SAMPLE_CYC(SAMPLE_CYC),
        .TX0_CYC   (TX0_CYC),
        .PW_CYC    (PW_CYC),
        .PL_CYC    (PL_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line_i),
        .fall_i      (fall),
        .rst_hit_i   (rst_hit),
        .rd_mode_i   (tx_mode_i),
        .tx_bit_i    (tx_bit_i),
        .pull_o      (pull_low_o),
        .rx_o        (rx),
        .reset_seen_o(reset_seen_o)
    );

    assign rx_valid_o = rx.valid;
    assign rx_bit_o   = rx.data;

    // R6: no pull in the cycle after a reset detection
    assert_reset_release_R6: assert property (@(posedge clk) disable iff (rst)
        reset_seen_o |-> !pull_low_o);

endmodule

// File: tb/owr_responder_test.sv
module owr_responder_test;
    localparam int CPU = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_low = 1'b0;
    logic tx_mode = 1'b0;
    logic tx_bit = 1'b0;
    logic line;
    logic pull_low, rx_valid, rx_bit, reset_seen;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign line = !(m_low || pull_low);

    owr_responder #(.CLK_PER_US(CPU)) uut (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .tx_mode_i   (tx_mode),
        .tx_bit_i    (tx_bit),
        .pull_low_o  (pull_low),
        .rx_valid_o  (rx_valid),
        .rx_bit_o    (rx_bit),
        .reset_seen_o(reset_seen)
    );

    // [1] = read mode, [0] = bit value
    localparam logic [1:0] VEC [12] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00,
                                        2'b11, 2'b10, 2'b00, 2'b00, 2'b11, 2'b10};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_slot(input bit b);
        int strobes = 0;
        int got = -1;
        int pulls = 0;
        tx_mode = 1'b0;
        for (int i = 0; i < 70 * CPU; i++) begin
            @(negedge clk);
            m_low = (i < (b ? 5 * CPU : 60 * CPU));
            if (i > 0) begin
                if (rx_valid) begin
                    strobes++;
                    got = rx_bit;
                end
                if (pull_low) pulls++;
            end
        end
        m_low = 1'b0;
        chk(strobes == 1, "R2 strobe count", strobes, 1);
        chk(got == int'(b), "R2 write bit", got, b);
        chk(pulls == 0, "R10 no pull in write", pulls, 0);
    endtask

    task automatic read_slot(input bit b);
        int strobes = 0;
        int mid = -1;
        int late = -1;
        tx_mode = 1'b1;
        tx_bit = b;
        for (int i = 0; i < 70 * CPU; i++) begin
            @(negedge clk);
            m_low = (i < CPU);
            if (i > 0 && rx_valid) strobes++;
            if (i == 12 * CPU) mid = line;
            if (i == 45 * CPU) late = line;
        end
        chk(mid == int'(b), "R4 read level at 12us", mid, b);
        chk(late == 1, "R5 released before slot end", late, 1);
        chk(strobes == 0, "R3 no strobe in read slot", strobes, 0);
        tx_mode = 1'b0;
    endtask

    task automatic hold_reset(output int pulses, output int pulls);
        pulses = 0;
        pulls = 0;
        for (int i = 0; i < 500 * CPU; i++) begin
            @(negedge clk);
            m_low = 1'b1;
            if (reset_seen) pulses++;
            if (i > 0 && pull_low) pulls++;
        end
        @(negedge clk);
        m_low = 1'b0;
        if (reset_seen) pulses++;
    endtask

    task automatic watch_presence(input bit glitch, output int rise, output int fall,
                                  output int strobes);
        bit prev = 1'b0;
        rise = -1;
        fall = -1;
        strobes = 0;
        for (int j = 1; j < 200 * CPU; j++) begin
            @(negedge clk);
            m_low = glitch && (j >= 10 * CPU) && (j < 15 * CPU);
            if (rx_valid) strobes++;
            if (pull_low && !prev && rise < 0) rise = j;
            if (!pull_low && prev && fall < 0) fall = j;
            prev = pull_low;
        end
        m_low = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int pulses, pulls, rise, fall, strobes;
        repeat (4) @(negedge clk);
        chk(pull_low == 0 && rx_valid == 0 && reset_seen == 0, "R1 outputs in reset",
            {pull_low, rx_valid, reset_seen}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pull_low == 0 && rx_valid == 0 && reset_seen == 0, "R1 outputs after reset",
            {pull_low, rx_valid, reset_seen}, 0);

        // vector table walk
        foreach (VEC[k]) begin
            if (VEC[k][1]) read_slot(VEC[k][0]);
            else write_slot(VEC[k][0]);
            repeat (5) @(negedge clk);
        end

        // reset with glitch during presence wait
        hold_reset(pulses, pulls);
        chk(pulses == 1, "R6 one reset strobe", pulses, 1);
        chk(pulls == 0, "R6 no pull during reset low", pulls, 0);
        watch_presence(1'b1, rise, fall, strobes);
        chk(rise >= 29 * CPU && rise <= 31 * CPU + 2, "R7 presence start", rise, 30 * CPU);
        chk(fall - rise >= 119 * CPU && fall - rise <= 121 * CPU, "R7 presence length",
            fall - rise, 120 * CPU);
        chk(strobes == 0, "R8 glitch ignored during presence sequence", strobes, 0);

        // slot works after presence
        write_slot(1'b1);
        read_slot(1'b0);

        // reset restarted during presence wait
        hold_reset(pulses, pulls);
        repeat (10 * CPU) @(negedge clk);
        chk(pull_low == 0, "R9 still waiting before restart", pull_low, 0);
        hold_reset(pulses, pulls);
        chk(pulses == 1, "R9 second reset strobe", pulses, 1);
        watch_presence(1'b0, rise, fall, strobes);
        chk(rise >= 29 * CPU && rise <= 31 * CPU + 2, "R9 presence from new release", rise,
            30 * CPU);
        chk(fall - rise >= 119 * CPU && fall - rise <= 121 * CPU, "R9 presence length",
            fall - rise, 120 * CPU);

        write_slot(1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule